// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns characters into asynchronous serial frames on a single TX line. A one-entry holding buffer sits in front of a frame shift register, so the next character can be queued while the current one is still going out. When a frame finishes and the buffer holds a character, the next frame starts on the very next bit boundary, with no idle gap between them.

Each write captures three things together: the low data byte, a separate ninth-bit input, and the frame settings (character size, parity mode, stop-bit count). Changing the settings later does not affect a character that is already queued. Bit timing comes from an external baud tick enable, and every bit lasts a fixed number of ticks.

A transmit-enable input decides who owns the pin. While the block owns it, the block drives TX. Otherwise TX follows the value from the pin's normal owner. Clearing the enable only hands the pin back after the buffer and the shift register are both empty.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `tx_drive` is 0, `tx_pin` equals `port_out`, `buf_empty` is 1 and `tx_done` is 0.
- R2: `tx_drive` rises on the first clock edge after `tx_enable` is seen high. While the block drives and no frame is in flight, `tx_pin` is 1.
- R3: A frame is one start bit (0), then the data bits with the least significant bit first, then an optional parity bit, then the stop bits (1).
- R4: `char_size` selects the number of data bits: 3'b000 gives 5, 3'b001 gives 6, 3'b010 gives 7, 3'b011 gives 8, 3'b111 gives 9, and every other code gives 8.
- R5: `parity_mode` 2'b10 appends an even parity bit and 2'b11 an odd parity bit, both computed over the data bits actually sent. 2'b00 and the reserved 2'b01 append no parity bit.
- R6: `two_stop`=1 gives two stop bits. `two_stop`=0 gives one.
- R7: A write with `wr_valid` captures `data_bit8` as data bit 8, together with `wr_data` and the frame settings. Changing any of these inputs after the write does not alter the queued frame.
- R8: An accepted write makes `buf_empty` 0 until the character moves into the shift register. A write while the buffer is full is ignored.
- R9: When the buffer holds a character at the end of a frame, the next start bit begins right after the last stop bit, so consecutive start bits are exactly 16 x frame-length ticks apart.
- R10: After `tx_enable` is cleared, `tx_drive` stays 1 until the buffer and the shift register are both empty. It then falls one cycle after `tx_done`, and `tx_pin` follows `port_out` again.
- R11: `tx_done` is a single-cycle pulse after the last stop bit of a frame, raised only when no further character is loaded. A run of back-to-back frames gives one pulse.
- R12: Writes are ignored while `tx_enable` is 0.
- R13: Each bit lasts 16 `baud_tick` pulses. Without ticks, the frame does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Oversampling tick enable, 16 per bit |
| tx_enable | input | 1 | Request to own and drive the TX pin |
| char_size | input | 3 | Character size code |
| parity_mode | input | 2 | Parity mode: 00 off, 01 reserved (off), 10 even, 11 odd |
| two_stop | input | 1 | 1 selects two stop bits |
| data_bit8 | input | 1 | Ninth data bit, captured at the byte write |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Low eight data bits |
| port_out | input | 1 | Pin value from the pin's normal owner |
| tx_pin | output | 1 | TX pin value |
| tx_drive | output | 1 | 1 while the block owns the pin |
| buf_empty | output | 1 | Holding buffer can accept a write |
| tx_done | output | 1 | One-cycle pulse when transmission drains |

## Verification
Two pairs of functions can fall in the same cycle:

- **The end of a frame and the load of the queued character.** The bench keeps the buffer full across a batch of frames with mixed settings. It judges this pair from the spacing of the start-bit edges, which must equal 16 ticks per bit of the preceding frame, and from the single `tx_done` pulse for the whole batch.
- **Releasing the pin and the drain of the last frame.** The bench clears `tx_enable` while one frame is shifting and another is buffered. Both frames must still come out whole, and `tx_drive` must fall exactly one cycle after `tx_done`.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

    localparam int DATA_W  = 9;
    localparam int FRAME_W = 1 + DATA_W + 1 + 2;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [2:0]        size;
        logic [1:0]        par;
        logic              two_stop;
    } tx_item_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;

    function automatic int size_bits(logic [2:0] code);
        case (code)
            3'b000:  return 5;
            3'b001:  return 6;
            3'b010:  return 7;
            3'b111:  return 9;
            default: return 8;
        endcase
    endfunction

    // Pre-builds a whole frame, LSB is sent first; unused upper bits idle high.
    function automatic frame_t build_frame(tx_item_t it);
        frame_t f;
        int     n;
        int     pos;
        logic   p;
        n      = size_bits(it.size);
        f.bits = '1;
        f.bits[0] = 1'b0;
        p = it.par[0];
        for (int i = 0; i < DATA_W; i++) begin
            if (i < n) begin
                f.bits[1+i] = it.data[i];
                p = p ^ it.data[i];
            end
        end
        pos = 1 + n;
        if (it.par[1]) begin
            f.bits[pos] = p;
            pos = pos + 1;
        end
        f.len = LEN_W'(pos + (it.two_stop ? 2 : 1));
        return f;
    endfunction

endpackage

// File: rtl/uftx_holding.sv
module uftx_holding
    import uftx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_valid,
    input  logic     wr_allow,
    input  tx_item_t item_in,
    input  logic     take,
    output logic     full,
    output tx_item_t item_out
);

    typedef struct packed {
        logic     full;
        tx_item_t item;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.full = 1'b0;
        end
        if (wr_valid && wr_allow && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.item = item_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full     = st_q.full;
    assign item_out = st_q.item;

    // R8: a write into a full buffer leaves the stored character untouched
    p_keep_item_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full && wr_valid |=> $stable(st_q.item));

endmodule

// File: rtl/uftx_shifter.sv
module uftx_shifter
    import uftx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
)(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     baud_tick,
    input  logic     run,
    input  logic     have_item,
    input  tx_item_t item,
    output logic     take,
    output logic     busy,
    output logic     line,
    output logic     done
);

    localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   left;
        logic [CNT_W-1:0]   tcnt;
        logic               done;
    } shf_t;

    shf_t   st_d, st_q;
    frame_t nxt;
    logic   frame_end;

    assign nxt = build_frame(item);

    always_comb begin
        st_d      = st_q;
        take      = 1'b0;
        frame_end = 1'b0;
        st_d.done = 1'b0;
        if (st_q.busy && baud_tick) begin
            if (st_q.tcnt == CNT_W'(OVERSAMPLE - 1)) begin
                st_d.tcnt = '0;
                st_d.bits = {1'b1, st_q.bits[FRAME_W-1:1]};
                st_d.left = st_q.left - 1'b1;
                if (st_q.left == LEN_W'(1)) begin
                    st_d.busy = 1'b0;
                    frame_end = 1'b1;
                end
            end else begin
                st_d.tcnt = st_q.tcnt + 1'b1;
            end
        end
        if (!st_d.busy && run && have_item) begin
            take      = 1'b1;
            st_d.busy = 1'b1;
            st_d.bits = nxt.bits;
            st_d.left = nxt.len;
            st_d.tcnt = '0;
        end
        st_d.done = frame_end && !take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.bits <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign line = st_q.busy ? st_q.bits[0] : 1'b1;
    assign done = st_q.done;

    // R3: every loaded frame opens with a low start bit
    p_start_bit_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (line == 1'b0));

    // R13: without a tick the frame in flight does not move
    p_hold_without_tick_r13: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && !baud_tick |=> $stable(st_q.bits) && $stable(st_q.left));

endmodule

// File: rtl/uftx_owner.sv
module uftx_owner (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pending,
    output logic drive
);

    typedef struct packed {
        logic drive;
    } own_t;

    own_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.drive = enable || pending;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drive = st_q.drive;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uftx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       tx_enable,
    input  logic [2:0] char_size,
    input  logic [1:0] parity_mode,
    input  logic       two_stop,
    input  logic       data_bit8,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic       port_out,
    output logic       tx_pin,
    output logic       tx_drive,
    output logic       buf_empty,
    output logic       tx_done
);

    tx_item_t wr_item;
    tx_item_t held;
    logic     full;
    logic     take;
    logic     busy;
    logic     line;
    logic     drive;
    logic     done;

    assign wr_item.data     = {data_bit8, wr_data};
    assign wr_item.size     = char_size;
    assign wr_item.par      = parity_mode;
    assign wr_item.two_stop = two_stop;

    uftx_holding u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_allow (tx_enable),
        .item_in  (wr_item),
        .take     (take),
        .full     (full),
        .item_out (held)
    );

    uftx_shifter #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .run       (drive),
        .have_item (full),
        .item      (held),
        .take      (take),
        .busy      (busy),
        .line      (line),
        .done      (done)
    );

    uftx_owner u_own (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (tx_enable),
        .pending (full || busy),
        .drive   (drive)
    );

    assign tx_pin    = drive ? line : port_out;
    assign tx_drive  = drive;
    assign buf_empty = !full;
    assign tx_done   = done;

    // R2: an owned pin with nothing in flight idles high
    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drive && !busy |-> tx_pin);

    // R11: completion is a single-cycle pulse
    p_done_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    // R12: with the enable low an empty buffer stays empty
    p_no_write_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable && buf_empty |=> buf_empty);

    // R10: the pin is released only once the buffer was empty
    p_release_drained_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_drive) |-> $past(buf_empty) && !$past(busy));

endmodule

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;

    typedef struct {
        logic [8:0] data;
        logic [2:0] size;
        logic [1:0] par;
        logic       ts;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       tx_enable = 1'b0;
    logic [2:0] char_size = 3'b011;
    logic [1:0] parity_mode = 2'b00;
    logic       two_stop = 1'b0;
    logic       data_bit8 = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       port_out = 1'b0;
    logic       tx_pin, tx_drive, buf_empty, tx_done;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   div = 1;
    int   done_cnt = 0;
    int   frames_sent = 0;
    int   frames_seen = 0;
    bit   finished = 0;
    exp_t exp_q[$];
    int   starts[$];

    uart_frame_tx u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_enable(tx_enable),
        .char_size(char_size), .parity_mode(parity_mode), .two_stop(two_stop),
        .data_bit8(data_bit8), .wr_valid(wr_valid), .wr_data(wr_data),
        .port_out(port_out), .tx_pin(tx_pin), .tx_drive(tx_drive),
        .buf_empty(buf_empty), .tx_done(tx_done)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int nbits(logic [2:0] c);
        if (c == 3'b000) return 5;
        if (c == 3'b001) return 6;
        if (c == 3'b010) return 7;
        if (c == 3'b111) return 9;
        return 8;
    endfunction

    function automatic int flen(logic [2:0] c, logic [1:0] p, logic ts);
        return 1 + nbits(c) + (p[1] ? 1 : 0) + (ts ? 2 : 1);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // baud tick source
    initial begin
        int t = 0;
        forever begin
            @(negedge clk);
            t++;
            baud_tick = ((t % div) == 0);
        end
    end

    // tx_done pulse counter and width check (R11)
    initial begin
        logic pd = 1'b0;
        forever begin
            @(negedge clk);
            if (tx_done) done_cnt++;
            if (tx_done && pd) check(0, "R11", "done wider than one cycle", 2, 1);
            pd = tx_done;
        end
    end

    // monitor: decodes frames on the line and compares against the scoreboard
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (!tx_drive) begin
                prev = 1'b1;
            end else if (prev && !tx_pin) begin
                starts.push_back(cyc);
                repeat (8 * div) @(negedge clk);
                check(tx_pin == 1'b0, "R3", "start bit", tx_pin, 0);
                if (exp_q.size() == 0) begin
                    check(0, "R8", "unexpected frame", 1, 0);
                end else begin
                    exp_t e;
                    int n;
                    logic [8:0] got;
                    logic [8:0] want;
                    logic par;
                    e = exp_q.pop_front();
                    n = nbits(e.size);
                    got = '0;
                    want = '0;
                    for (int i = 0; i < n; i++) begin
                        repeat (16 * div) @(negedge clk);
                        got[i] = tx_pin;
                        want[i] = e.data[i];
                    end
                    frames_seen++;
                    check(got == want, "R3/R4/R7", "data bits", got, want);
                    if (e.par[1]) begin
                        par = e.par[0] ^ (^want);
                        repeat (16 * div) @(negedge clk);
                        check(tx_pin == par, "R5", "parity bit", tx_pin, par);
                    end
                    repeat (16 * div) @(negedge clk);
                    check(tx_pin == 1'b1, "R3", "stop bit", tx_pin, 1);
                    if (e.ts) begin
                        repeat (16 * div) @(negedge clk);
                        check(tx_pin == 1'b1, "R6", "second stop bit", tx_pin, 1);
                    end
                end
                prev = 1'b1;
            end else begin
                prev = tx_pin;
            end
        end
    end

    task automatic send(logic [8:0] d, logic [2:0] sz, logic [1:0] pm, logic ts);
        exp_t e;
        while (!buf_empty) @(negedge clk);
        data_bit8 = d[8];
        wr_data = d[7:0];
        char_size = sz;
        parity_mode = pm;
        two_stop = ts;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        // R7: disturb the captured inputs right after the write
        data_bit8 = ~d[8];
        wr_data = ~d[7:0];
        char_size = 3'b011;
        parity_mode = 2'b00;
        two_stop = 1'b0;
        e.data = d; e.size = sz; e.par = pm; e.ts = ts;
        exp_q.push_back(e);
        frames_sent++;
    endtask

    task automatic wait_done();
        int c = done_cnt;
        while (done_cnt == c) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int d0;
        int t0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tx_pin == 1'b0, "R1", "pin follows port_out=0", tx_pin, 0);
        check(tx_drive == 1'b0, "R1", "drive", tx_drive, 0);
        check(buf_empty == 1'b1, "R1", "buf_empty", buf_empty, 1);
        check(tx_done == 1'b0, "R1", "done", tx_done, 0);
        port_out = 1'b1;
        @(negedge clk);
        check(tx_pin == 1'b1, "R1", "pin follows port_out=1", tx_pin, 1);
        rst_n = 1'b1;
        port_out = 1'b0;
        @(negedge clk);

        // R12: write while disabled is dropped
        wr_data = 8'h3C;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        check(buf_empty == 1'b1, "R12", "buffer after disabled write", buf_empty, 1);
        check(tx_drive == 1'b0, "R12", "drive after disabled write", tx_drive, 0);
        repeat (40) @(negedge clk);
        check(starts.size() == 0, "R12", "frames after disabled write", starts.size(), 0);

        // R2: enable takes the pin, idle high
        tx_enable = 1'b1;
        @(negedge clk);
        check(tx_drive == 1'b1, "R2", "drive after enable", tx_drive, 1);
        check(tx_pin == 1'b1, "R2", "idle line high", tx_pin, 1);

        // batch of mixed formats, back-to-back (R3-R7, R9, R11)
        starts.delete();
        d0 = done_cnt;
        send(9'h0A5, 3'b011, 2'b00, 1'b0);
        send(9'h013, 3'b000, 2'b10, 1'b0);
        send(9'h02C, 3'b001, 2'b11, 1'b1);
        send(9'h05A, 3'b010, 2'b01, 1'b0);
        send(9'h1C3, 3'b111, 2'b10, 1'b0);
        send(9'h0F0, 3'b100, 2'b11, 1'b0);
        send(9'h155, 3'b111, 2'b00, 1'b1);
        wait_done();
        repeat (20) @(negedge clk);
        check(done_cnt - d0 == 1, "R11", "done pulses for batch", done_cnt - d0, 1);
        check(starts.size() == 7, "R9", "frames in batch", starts.size(), 7);
        if (starts.size() == 7) begin
            check(starts[1] - starts[0] == 16 * flen(3'b011, 2'b00, 1'b0), "R9", "gap 1", starts[1] - starts[0], 160);
            check(starts[2] - starts[1] == 16 * flen(3'b000, 2'b10, 1'b0), "R9", "gap 2", starts[2] - starts[1], 128);
            check(starts[3] - starts[2] == 16 * flen(3'b001, 2'b11, 1'b1), "R9", "gap 3", starts[3] - starts[2], 160);
            check(starts[4] - starts[3] == 16 * flen(3'b010, 2'b01, 1'b0), "R9", "gap 4", starts[4] - starts[3], 144);
            check(starts[5] - starts[4] == 16 * flen(3'b111, 2'b10, 1'b0), "R9", "gap 5", starts[5] - starts[4], 192);
            check(starts[6] - starts[5] == 16 * flen(3'b100, 2'b11, 1'b0), "R4", "gap 6 code 100", starts[6] - starts[5], 176);
        end

        // R8: two writes on consecutive cycles while idle, second dropped
        starts.delete();
        wr_data = 8'h81; data_bit8 = 1'b0; char_size = 3'b011; parity_mode = 2'b00; two_stop = 1'b0;
        wr_valid = 1'b1;
        @(negedge clk);
        check(buf_empty == 1'b0, "R8", "buffer full after write", buf_empty, 0);
        begin
            exp_t e;
            e.data = 9'h081; e.size = 3'b011; e.par = 2'b00; e.ts = 1'b0;
            exp_q.push_back(e);
            frames_sent++;
        end
        wr_data = 8'h7E;
        @(negedge clk);
        wr_valid = 1'b0;
        wait_done();
        repeat (200) @(negedge clk);
        check(starts.size() == 1, "R8", "frames from double write", starts.size(), 1);

        // R10: disable with one frame shifting and one buffered
        send(9'h0C1, 3'b011, 2'b10, 1'b0);
        send(9'h03E, 3'b010, 2'b00, 1'b1);
        tx_enable = 1'b0;
        repeat (50) @(negedge clk);
        check(tx_drive == 1'b1, "R10", "drive held while draining", tx_drive, 1);
        while (!tx_done) @(negedge clk);
        done_cnt = done_cnt;
        check(tx_drive == 1'b1, "R10", "drive at done", tx_drive, 1);
        @(negedge clk);
        check(tx_drive == 1'b0, "R10", "drive released", tx_drive, 0);
        check(tx_pin == port_out, "R10", "pin back to owner", tx_pin, port_out);
        check(exp_q.size() == 0, "R10", "queued frames drained", exp_q.size(), 0);

        // R13: ticks every second cycle double the bit time
        tx_enable = 1'b1;
        div = 2;
        repeat (4) @(negedge clk);
        starts.delete();
        send(9'h0B7, 3'b011, 2'b11, 1'b0);
        wait_done();
        t0 = (starts.size() > 0) ? starts[0] : 0;
        check((cyc - t0 >= 350) && (cyc - t0 <= 356), "R13", "frame duration at half tick rate", cyc - t0, 352);

        repeat (20) @(negedge clk);
        check(frames_seen == frames_sent, "R3", "frames seen vs sent", frames_seen, frames_sent);
        check(exp_q.size() == 0, "R3", "scoreboard empty", exp_q.size(), 0);
        finish_run();
    end

endmodule